// File: doc/BRIEF.md
# Serial Link Bring-Up Sequencer

This block masters a simple register write bus and plays back a fixed list of configuration writes that brings a multi-link serial backplane interface up in eight-link cell mode. A single-cycle `start` pulse launches the list. First, every serial channel gets its clock-recovery and overhead-handling control byte. Then come the global link-management setting and the mode select. After those, a soft reset is pulsed, the transmitter is marked as configured, and the receive FIFOs of both channel groups are flushed. Each reset bit is pulsed as a pair of writes: one sets it and one clears it.

After the FIFO flush the sequencer stops and watches a vector of per-link receive-good inputs. When every bit of that vector is high, it issues one last write that turns on automatic bundling and drops the rejoin bits, and then it raises `done`. If the links do not all come good within a parameterised number of cycles, the sequencer raises `timeout` and skips the final write. Either flag stays high until the next `start` pulse.

Top module: `link_init_seq`

## Requirements
- R1: After synchronous reset, `wr_valid`, `done` and `timeout` are all low.
- R2: Once a write is presented, `wr_valid`, `wr_addr` and `wr_data` hold unchanged until the cycle in which `wr_ready` is high. A write transfers at the rising clock edge where both `wr_valid` and `wr_ready` are high.
- R3: The first NUM_CHAN writes go to channels 0 to NUM_CHAN-1 in ascending order. Channel i is written at address CHAN_BASE + i*CHAN_STRIDE with data 0x82.
- R4: Next, 0x1B is written to 0x30A03, and then 0x01 is written to 0x30A05.
- R5: Next, 0x01 and then 0x00 are written to 0x30A06, followed by 0x01 to 0x30A07.
- R6: Next come exactly four writes in this order: 0x20 to 0x30005, 0x20 to 0x30105, 0x00 to 0x30005, 0x00 to 0x30105.
- R7: After the FIFO writes, no write is issued while any bit of `link_good` is low. Once all bits are high, 0x49 is written to 0x30A03, and this is the last write of the run.
- R8: If `link_good` is not all high for TIMEOUT_CYC consecutive waiting cycles, `timeout` rises at the clock edge that ends the TIMEOUT_CYC-th waiting cycle. The final write is never issued in that run.
- R9: `done` rises at the clock edge after the final write transfers. It stays high until the next `start` and falls at the edge that samples that `start`.
- R10: A `start` pulse that arrives while a run is in progress, whether writing or waiting, has no effect on the written sequence.
- R11: `done` and `timeout` are never high together, and `wr_valid` is low whenever either of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, sampled while idle, done or timed out |
| wr_valid | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_ready | input | 1 | Slave accepts the write on this edge |
| link_good | input | NUM_LINKS | Per-link receive-good status |
| done | output | 1 | Sequence finished with the final write |
| timeout | output | 1 | Link wait expired; final write skipped |

## Verification
The bench runs the whole sequence under four slave back-pressure patterns and compares every transferred write with the list computed from the requirements. A design that advanced without waiting for `wr_ready`, or changed the address during a stall, would drop or repeat entries. A restart pulse is injected during the write phase and again during the wait phase, because a sequencer that re-arms on it would replay the list. The wait phase is tested with the links coming good late, coming good before the wait starts, and with exactly one link held low. A design that ORed the status bits would issue the final write early, and an off-by-one timer would move the `timeout` edge by one cycle, which the bench measures exactly.

// File: rtl/link_init_pkg.sv
package link_init_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 8;
    localparam int COMMON_STEPS = 9;

    localparam logic [ADDR_W-1:0] REG_LINK_MGMT = 20'h30A03;
    localparam logic [ADDR_W-1:0] REG_MODE      = 20'h30A05;
    localparam logic [ADDR_W-1:0] REG_SOFTRST   = 20'h30A06;
    localparam logic [ADDR_W-1:0] REG_TX_READY  = 20'h30A07;
    localparam logic [ADDR_W-1:0] REG_GRP_A_RST = 20'h30005;
    localparam logic [ADDR_W-1:0] REG_GRP_B_RST = 20'h30105;

    localparam logic [DATA_W-1:0] VAL_CHAN_CFG  = 8'h82;
    localparam logic [DATA_W-1:0] VAL_MGMT_INIT = 8'h1B;
    localparam logic [DATA_W-1:0] VAL_MGMT_FINAL = 8'h49;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_WAIT,
        ST_DONE,
        ST_TIMEOUT
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_op_t;

    function automatic wr_op_t common_op(input int unsigned k);
        wr_op_t op;
        case (k)
            0: op = '{addr: REG_LINK_MGMT, data: VAL_MGMT_INIT};
            1: op = '{addr: REG_MODE,      data: 8'h01};
            2: op = '{addr: REG_SOFTRST,   data: 8'h01};
            3: op = '{addr: REG_SOFTRST,   data: 8'h00};
            4: op = '{addr: REG_TX_READY,  data: 8'h01};
            5: op = '{addr: REG_GRP_A_RST, data: 8'h20};
            6: op = '{addr: REG_GRP_B_RST, data: 8'h20};
            7: op = '{addr: REG_GRP_A_RST, data: 8'h00};
            default: op = '{addr: REG_GRP_B_RST, data: 8'h00};
        endcase
        return op;
    endfunction

    function automatic wr_op_t final_op();
        return '{addr: REG_LINK_MGMT, data: VAL_MGMT_FINAL};
    endfunction

endpackage

// File: rtl/link_init_table.sv
module link_init_table
    import link_init_pkg::*;
#(
    parameter int unsigned        NUM_CHAN    = 8,
    parameter logic [ADDR_W-1:0]  CHAN_BASE   = 20'h30804,
    parameter logic [ADDR_W-1:0]  CHAN_STRIDE = 20'h00010,
    parameter int unsigned        IDX_W       = 5
) (
    input  logic [IDX_W-1:0] idx,
    output wr_op_t           op
);
    localparam int unsigned PRE_LAST = NUM_CHAN + COMMON_STEPS;

    wr_op_t chan_op [NUM_CHAN];

    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
        assign chan_op[g].addr = CHAN_BASE + ADDR_W'(g) * CHAN_STRIDE;
        assign chan_op[g].data = VAL_CHAN_CFG;
    end

    always_comb begin
        int unsigned i;
        i = int'(idx);
        if (i < NUM_CHAN)
            op = chan_op[i];
        else if (i < PRE_LAST)
            op = common_op(i - NUM_CHAN);
        else
            op = final_op();
    end
endmodule

// File: rtl/link_wr_port.sv
module link_wr_port
    import link_init_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  wr_op_t            op_in,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              accept
);
    wr_op_t held;

    assign accept  = wr_valid && wr_ready;
    assign wr_addr = held.addr;
    assign wr_data = held.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            held     <= '0;
        end else if (load) begin
            wr_valid <= 1'b1;
            held     <= op_in;
        end else if (accept) begin
            wr_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/link_wait_timer.sv
module link_wait_timer #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    assign expired = run && (cnt == CNT_W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (run && !expired)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/link_init_seq.sv
module link_init_seq
    import link_init_pkg::*;
#(
    parameter int unsigned        NUM_CHAN    = 8,
    parameter int unsigned        NUM_LINKS   = 8,
    parameter int unsigned        TIMEOUT_CYC = 1000,
    parameter logic [ADDR_W-1:0]  CHAN_BASE   = 20'h30804,
    parameter logic [ADDR_W-1:0]  CHAN_STRIDE = 20'h00010
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    output logic                 wr_valid,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [DATA_W-1:0]    wr_data,
    input  logic                 wr_ready,
    input  logic [NUM_LINKS-1:0] link_good,
    output logic                 done,
    output logic                 timeout
);
    localparam int unsigned TOTAL  = NUM_CHAN + COMMON_STEPS + 1;
    localparam int unsigned IDX_W  = $clog2(TOTAL + 1);
    localparam logic [IDX_W-1:0] LAST_PRE  = IDX_W'(TOTAL - 2);
    localparam logic [IDX_W-1:0] FINAL_IDX = IDX_W'(TOTAL - 1);

    seq_state_e       state, state_nx;
    logic [IDX_W-1:0] idx, idx_nx;
    logic             load, accept, all_good, expired;
    wr_op_t           op;

    assign all_good = &link_good;

    link_init_table #(
        .NUM_CHAN   (NUM_CHAN),
        .CHAN_BASE  (CHAN_BASE),
        .CHAN_STRIDE(CHAN_STRIDE),
        .IDX_W      (IDX_W)
    ) u_table (
        .idx(idx_nx),
        .op (op)
    );

    link_wr_port u_port (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .op_in   (op),
        .wr_ready(wr_ready),
        .wr_valid(wr_valid),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .accept  (accept)
    );

    link_wait_timer #(
        .LIMIT(TIMEOUT_CYC)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (state != ST_WAIT),
        .run    ((state == ST_WAIT) && !all_good),
        .expired(expired)
    );

    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        load     = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE, ST_TIMEOUT: begin
                if (start) begin
                    state_nx = ST_WRITE;
                    idx_nx   = '0;
                    load     = 1'b1;
                end
            end
            ST_WRITE: begin
                if (accept) begin
                    if (idx == FINAL_IDX) begin
                        state_nx = ST_DONE;
                    end else if (idx == LAST_PRE) begin
                        state_nx = ST_WAIT;
                        idx_nx   = FINAL_IDX;
                    end else begin
                        idx_nx = idx + 1'b1;
                        load   = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (all_good) begin
                    state_nx = ST_WRITE;
                    idx_nx   = FINAL_IDX;
                    load     = 1'b1;
                end else if (expired) begin
                    state_nx = ST_TIMEOUT;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end

    assign done    = (state == ST_DONE);
    assign timeout = (state == ST_TIMEOUT);
endmodule

// File: rtl/link_init_seq_chk.sv
module link_init_seq_chk
    import link_init_pkg::*;
#(
    parameter int unsigned NUM_LINKS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 wr_valid,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [DATA_W-1:0]    wr_data,
    input logic                 wr_ready,
    input logic [NUM_LINKS-1:0] link_good,
    input logic                 done,
    input logic                 timeout
);
    // R2: stalled request holds address, data and valid
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R11: flags are exclusive
    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && timeout));

    // R11: bus quiet once finished
    a_r11_quiet_when_finished: assert property (@(posedge clk) disable iff (rst)
        (done || timeout) |-> !wr_valid);

    // R9: done rises only after a transfer
    a_r9_done_after_xfer: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(wr_valid && wr_ready));

    // R9: done holds without start
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R8: timeout holds without start
    a_r8_timeout_sticky: assert property (@(posedge clk) disable iff (rst)
        (timeout && !start) |=> timeout);

    // R7: the bundling write needs every link good when it is first raised
    a_r7_final_needs_links: assert property (@(posedge clk) disable iff (rst)
        ($rose(wr_valid) && wr_addr == REG_LINK_MGMT && wr_data == VAL_MGMT_FINAL)
            |-> $past(&link_good));
endmodule

bind link_init_seq link_init_seq_chk #(.NUM_LINKS(NUM_LINKS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_ready (wr_ready),
    .link_good(link_good),
    .done     (done),
    .timeout  (timeout)
);

// File: tb/link_init_seq_tb.sv
module link_init_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NC  = 4;
    localparam int NL  = 8;
    localparam int TO  = 20;
    localparam int N_ALL = NC + 10;
    localparam logic [19:0] BASE = 20'h30804;
    localparam logic [19:0] STRD = 20'h00010;

    logic clk = 0, rst = 1, start = 0, wr_ready = 0;
    logic wr_valid, done, timeout;
    logic [19:0] wr_addr;
    logic [7:0]  wr_data;
    logic [NL-1:0] link_good = '0;

    int errors = 0, checks = 0;
    int wr_count = 0;
    int mode = 0;
    int cyc = 0;
    logic [27:0] log_q [0:63];
    logic [7:0] lfsr = 8'h5A;
    logic pend = 0;
    logic [27:0] pend_op;

    link_init_seq #(.NUM_CHAN(NC), .NUM_LINKS(NL), .TIMEOUT_CYC(TO),
                    .CHAN_BASE(BASE), .CHAN_STRIDE(STRD)) u_dut (
        .clk(clk), .rst(rst), .start(start), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .link_good(link_good), .done(done), .timeout(timeout));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [27:0] exp_op(input int i);
        if (i < NC) return {BASE + 20'(i) * STRD, 8'h82};
        case (i - NC)
            0: return {20'h30A03, 8'h1B};
            1: return {20'h30A05, 8'h01};
            2: return {20'h30A06, 8'h01};
            3: return {20'h30A06, 8'h00};
            4: return {20'h30A07, 8'h01};
            5: return {20'h30005, 8'h20};
            6: return {20'h30105, 8'h20};
            7: return {20'h30005, 8'h00};
            8: return {20'h30105, 8'h00};
            default: return {20'h30A03, 8'h49};
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // slave model and write monitor
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (mode)
                0: wr_ready = 1'b1;
                1: wr_ready = cyc[0];
                2: wr_ready = (cyc % 3) == 0;
                default: wr_ready = lfsr[0];
            endcase
            if (pend) begin
                checks++;
                if (!wr_valid || {wr_addr, wr_data} !== pend_op) begin
                    errors++;
                    $display("FAIL R2: actual=%0h expected=%0h", {wr_addr, wr_data}, pend_op);
                end
            end
            pend    = wr_valid && !wr_ready;
            pend_op = {wr_addr, wr_data};
            if (wr_valid && wr_ready) begin
                if (wr_count < 64) log_q[wr_count] = {wr_addr, wr_data};
                wr_count++;
            end
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 start = 1;
        @(posedge clk); #1 start = 0;
    endtask

    task automatic check_log(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            string r;
            r = (i < NC) ? "R3" : (i < NC + 2) ? "R4" : (i < NC + 5) ? "R5" :
                (i < NC + 9) ? "R6" : "R7";
            check($sformatf("%s %s idx%0d", r, tag, i), {4'h0, log_q[i]}, {4'h0, exp_op(i)});
        end
    endtask

    task automatic full_run(input int m, input int good_delay, input bit early_good, input bit restart);
        mode = m;
        wr_count = 0;
        link_good = early_good ? '1 : '0;
        pulse_start();
        @(negedge clk);
        check("R9 done cleared by start", {31'b0, done}, 0);
        if (restart) begin
            wait (wr_count == 2);
            pulse_start();   // R10: ignored during writes
        end
        wait (wr_count == N_ALL - 1);
        if (!early_good) begin
            if (restart) pulse_start();   // R10: ignored during wait
            repeat (good_delay) @(posedge clk);
            @(negedge clk);
            check("R7 no write while links down", wr_count, N_ALL - 1);
            check("R7 bus idle while waiting", {31'b0, wr_valid}, 0);
            @(posedge clk); #1 link_good = '1;
        end
        wait (done || timeout);
        @(negedge clk);
        check("R9 done raised", {31'b0, done}, 1);
        check("R8 no timeout", {31'b0, timeout}, 0);
        check("R10 write count", wr_count, N_ALL);
        check_log(N_ALL, $sformatf("mode%0d", m));
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R9 done held", {31'b0, done}, 1);
        check("R11 bus idle when done", {31'b0, wr_valid}, 0);
    endtask

    task automatic timeout_run(input int m);
        mode = m;
        wr_count = 0;
        link_good = 8'hFE;   // one link short
        pulse_start();
        wait (wr_count == N_ALL - 1);
        @(posedge clk);       // last FIFO write transfers here
        repeat (TO - 1) @(posedge clk);
        @(negedge clk);
        check("R8 timeout not yet", {31'b0, timeout}, 0);
        @(posedge clk);
        @(negedge clk);
        check("R8 timeout edge", {31'b0, timeout}, 1);
        check("R8 no final write", wr_count, N_ALL - 1);
        check("R11 done low on timeout", {31'b0, done}, 0);
        check_log(N_ALL - 1, "timeout");
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R8 timeout held", {31'b0, timeout}, 1);
        check("R8 still no final write", wr_count, N_ALL - 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid after reset", {31'b0, wr_valid}, 0);
        check("R1 done after reset", {31'b0, done}, 0);
        check("R1 timeout after reset", {31'b0, timeout}, 0);
        #1 rst = 0;
        for (int m = 0; m < 4; m++) full_run(m, 7 + m * 3, 1'b0, m == 2);
        full_run(3, 0, 1'b1, 1'b0);
        timeout_run(1);
        full_run(0, 5, 1'b0, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule